// File: doc/BRIEF.md
# Dual-Mode SPI Configuration Interface

This block is the serial configuration port of a sensor conditioning channel. A host writes single-byte commands over a four-wire serial link (chip select active low, clock idling low, data in, data out). Each accepted command updates one of six configuration values: a 4-bit clock prescaler code, an SDO-disable flag, a channel select bit, a 6-bit band-pass code, a 6-bit gain code and a 5-bit integrator time-constant code. The analog stages that consume these values are outside the block.

The port has two protocol personalities. After reset it echoes: the data-out line repeats the incoming bits of the current frame. A dedicated command switches it for good into a pipelined personality. In that mode the byte shifted out during a frame answers the command of the previous accepted frame. The answers include the two halves of a 10-bit measurement result and, in test mode, three clamp flags. The serial clock, data and chip-select inputs are brought into the system clock domain by a two-flop synchroniser. The serial clock must run at least four times slower than the system clock. The integrate level, the test pin, the result and the clamp flags are synchronous to the system clock. No streaming data path exists, so the port has no valid/ready handshake.

Top module: `dualmode_cfg_spi`

## Requirements
- R1: After reset all six configuration values are 0, the port is in echo mode, and `sdo_oe` is 0 while `cs_n` is high, whatever `sclk` and `sdi` do.
- R2: A frame is MSB first, with `sdi` sampled on each falling `sclk` edge while `cs_n` is low. It is committed at the `cs_n` rising edge only if exactly 8 falling edges occurred. A frame of any other length changes no configuration value and no pending response.
- R3: A frame that ends while `integrate` is 1 is discarded: no configuration value and no pending response changes.
- R4: Command `010pppps` sets the prescaler code to `pppp` and the SDO-disable flag to `s`, but only when `pppp` is 8 or less. A larger code makes the whole frame count as discarded.
- R5: Command `1110000c` sets the channel select to `c`, `00bbbbbb` sets the band-pass code, `10gggggg` sets the gain code and `110ttttt` sets the time-constant code. Any byte not listed in R4, R5, R8 or R10 changes no configuration value.
- R6: `sdo_oe` is 1 exactly while `cs_n` is low and the SDO-disable flag is 0. `sdo` reads 0 whenever `sdo_oe` is 0.
- R7: In echo mode the bits on `sdo` during a frame equal the bits received on `sdi`.
- R8: Byte 0x71 switches the port to pipelined mode. Only reset returns it to echo mode.
- R9: In pipelined mode, the byte shifted out MSB first during a frame is the response to the last accepted command. The responses are: for a prescaler command, result bits 7:0; for a channel command, result bits 9:8 followed by six zeros; for band-pass, 0x01; for gain, 0xE0; for time-constant, 0x71; for 0x71, 0x8E; for an unrecognised byte, 0x00. `sdo` changes on rising `sclk` edges.
- R10: With `test_n` low, byte 0xF8 forces pipelined mode, and its response is `{5'b0, int, bpf, gain}` taken from `clamp_flags[2:0]`, where bit 0 is the gain stage, bit 1 the band-pass stage and bit 2 the integrator stage. With `test_n` high, 0xF8 is an unrecognised byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data in |
| integrate | input | 1 | 1 while integrating; frames are discarded |
| test_n | input | 1 | Test mode when low |
| result | input | 10 | Measurement result returned in pipelined mode |
| clamp_flags | input | 3 | Clamp flags: bit0 gain, bit1 band-pass, bit2 integrator |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the tri-state SDO driver |
| presc_code | output | 4 | Clock prescaler code |
| sdo_off | output | 1 | SDO-disable flag |
| chan_sel | output | 1 | Channel select |
| bpf_code | output | 6 | Band-pass code |
| gain_code | output | 6 | Gain code |
| tc_code | output | 5 | Integrator time-constant code |

## Verification
Configuration outputs settle four system cycles after the `cs_n` rising edge: two synchroniser stages, the edge register and the commit register. The response register loads three cycles after `cs_n` falls, and `sdo` moves three cycles after each rising `sclk`. The bench holds each `sclk` phase for five system cycles. It reads `sdo` just before each falling edge and checks registers eight cycles after raising `cs_n`, so every result is sampled well after it is due and well before the next stimulus. Discarded, short and long frames are judged by the register outputs and by the response carried into the next frame.

// File: rtl/cfgspi_pkg.sv
package cfgspi_pkg;
  localparam int FRAME_BITS = 8;
  localparam int RES_W      = 10;
  localparam int PRESC_W    = 4;
  localparam int PRESC_MAX  = 8;
  localparam int BPF_W      = 6;
  localparam int GAIN_W     = 6;
  localparam int TC_W       = 5;
  localparam int CLAMP_W    = 3;

  typedef logic [FRAME_BITS-1:0] byte_t;

  typedef struct packed {
    logic [PRESC_W-1:0] presc;
    logic               sdo_off;
    logic               chan;
    logic [BPF_W-1:0]   bpf;
    logic [GAIN_W-1:0]  gain;
    logic [TC_W-1:0]    tc;
  } cfg_t;

  localparam byte_t CMD_ADV   = 8'h71;
  localparam byte_t CMD_CLAMP = 8'hF8;
  localparam byte_t RSP_BPF   = 8'h01;
  localparam byte_t RSP_GAIN  = 8'hE0;
  localparam byte_t RSP_TC    = 8'h71;
  localparam byte_t RSP_ADV   = 8'h8E;
  localparam byte_t RSP_NONE  = 8'h00;
endpackage

// File: rtl/cfgspi_sync.sv
module cfgspi_sync #(
  parameter int             W      = 3,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   INIT   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= INIT;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/cfgspi_rx.sv
module cfgspi_rx
  import cfgspi_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cs_low,
  input  logic  cs_fall,
  input  logic  cs_rise,
  input  logic  sclk_fall,
  input  logic  sdi_s,
  output logic  frame_ok,
  output byte_t frame_byte
);
  localparam int CNT_MAX = FRAME_BITS + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] cnt;
  byte_t            sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      sr       <= '0;
      frame_ok <= 1'b0;
    end else begin
      frame_ok <= cs_rise && (cnt == CNT_W'(FRAME_BITS));
      if (cs_fall) begin
        cnt <= '0;
      end else if (cs_low && sclk_fall) begin
        sr <= {sr[FRAME_BITS-2:0], sdi_s};
        if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
      end
    end
  end

  assign frame_byte = sr;

  // R2: a commit appears only right after chip select rises
  a_r2_commit_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> $past(cs_rise));
  // R2: the bit counter saturates and never wraps
  a_r2_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(CNT_MAX));
endmodule

// File: rtl/cfgspi_regs.sv
module cfgspi_regs
  import cfgspi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_ok,
  input  byte_t              frame_byte,
  input  logic               integrate,
  input  logic               test_n,
  input  logic [RES_W-1:0]   result,
  input  logic [CLAMP_W-1:0] clamp_flags,
  output cfg_t               cfg,
  output logic               piped,
  output byte_t              resp
);
  cfg_t  cfg_n;
  logic  piped_n;
  byte_t resp_n;
  byte_t cmd;

  assign cmd = frame_byte;

  always_comb begin
    cfg_n   = cfg;
    piped_n = piped;
    resp_n  = resp;
    if (frame_ok && !integrate) begin
      casez (cmd)
        CMD_ADV: begin
          piped_n = 1'b1;
          resp_n  = RSP_ADV;
        end
        CMD_CLAMP: begin
          if (!test_n) begin
            piped_n = 1'b1;
            resp_n  = {{(FRAME_BITS-CLAMP_W){1'b0}}, clamp_flags};
          end else begin
            resp_n  = RSP_NONE;
          end
        end
        8'b010?????: begin
          if (cmd[PRESC_W:1] <= PRESC_W'(PRESC_MAX)) begin
            cfg_n.presc   = cmd[PRESC_W:1];
            cfg_n.sdo_off = cmd[0];
            resp_n        = result[FRAME_BITS-1:0];
          end
        end
        8'b1110000?: begin
          cfg_n.chan = cmd[0];
          resp_n     = {result[RES_W-1:FRAME_BITS], {(2*FRAME_BITS-RES_W){1'b0}}};
        end
        8'b00??????: begin
          cfg_n.bpf = cmd[BPF_W-1:0];
          resp_n    = RSP_BPF;
        end
        8'b10??????: begin
          cfg_n.gain = cmd[GAIN_W-1:0];
          resp_n     = RSP_GAIN;
        end
        8'b110?????: begin
          cfg_n.tc = cmd[TC_W-1:0];
          resp_n   = RSP_TC;
        end
        default: resp_n = RSP_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg   <= '0;
      piped <= 1'b0;
      resp  <= RSP_NONE;
    end else begin
      cfg   <= cfg_n;
      piped <= piped_n;
      resp  <= resp_n;
    end
  end

  // R2: without a commit nothing moves
  a_r2_quiet_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |=> ($stable(cfg) && $stable(resp) && $stable(piped)));
  // R3: frames during integration are discarded
  a_r3_integrate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && integrate) |=> ($stable(cfg) && $stable(resp)));
  // R4: the prescaler code never leaves its legal range
  a_r4_presc_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.presc <= PRESC_W'(PRESC_MAX));
  // R8: pipelined mode is sticky
  a_r8_pipe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    piped |=> piped);
endmodule

// File: rtl/cfgspi_tx.sv
module cfgspi_tx
  import cfgspi_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cs_low,
  input  logic  cs_fall,
  input  logic  sclk_rise,
  input  logic  sdi_s,
  input  logic  piped,
  input  logic  sdo_off,
  input  byte_t resp,
  output logic  sdo,
  output logic  sdo_oe
);
  byte_t sr;
  logic  armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr    <= '0;
      armed <= 1'b0;
    end else if (cs_fall) begin
      sr    <= resp;
      armed <= 1'b0;
    end else if (cs_low && sclk_rise) begin
      if (armed) sr <= {sr[FRAME_BITS-2:0], 1'b0};
      armed <= 1'b1;
    end
  end

  assign sdo_oe = cs_low && !sdo_off;
  assign sdo    = !sdo_oe ? 1'b0 : (piped ? sr[FRAME_BITS-1] : sdi_s);

  // R6: the driver is never enabled with chip select high
  a_r6_oe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> cs_low);
  // R9: the response register takes the pending response at frame start
  a_r9_load_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (sr == $past(resp)));
endmodule

// File: rtl/dualmode_cfg_spi.sv
module dualmode_cfg_spi
  import cfgspi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic               sdi,
  input  logic               integrate,
  input  logic               test_n,
  input  logic [RES_W-1:0]   result,
  input  logic [CLAMP_W-1:0] clamp_flags,
  output logic               sdo,
  output logic               sdo_oe,
  output logic [PRESC_W-1:0] presc_code,
  output logic               sdo_off,
  output logic               chan_sel,
  output logic [BPF_W-1:0]   bpf_code,
  output logic [GAIN_W-1:0]  gain_code,
  output logic [TC_W-1:0]    tc_code
);
  logic [2:0] pins_s;
  logic       cs_s, sclk_s, sdi_s;
  logic       cs_d, sclk_d;
  logic       cs_fall, cs_rise, sclk_fall, sclk_rise, cs_low;
  logic       frame_ok, piped;
  byte_t      frame_byte, resp;
  cfg_t       cfg;

  cfgspi_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b101)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdi}), .q(pins_s));

  assign {cs_s, sclk_s, sdi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
    end
  end

  assign cs_low    = !cs_s;
  assign cs_fall   = cs_d && !cs_s;
  assign cs_rise   = !cs_d && cs_s;
  assign sclk_fall = sclk_d && !sclk_s;
  assign sclk_rise = !sclk_d && sclk_s;

  cfgspi_rx u_rx (
    .clk(clk), .rst_n(rst_n), .cs_low(cs_low), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .sclk_fall(sclk_fall), .sdi_s(sdi_s),
    .frame_ok(frame_ok), .frame_byte(frame_byte));

  cfgspi_regs u_regs (
    .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .frame_byte(frame_byte),
    .integrate(integrate), .test_n(test_n), .result(result),
    .clamp_flags(clamp_flags), .cfg(cfg), .piped(piped), .resp(resp));

  cfgspi_tx u_tx (
    .clk(clk), .rst_n(rst_n), .cs_low(cs_low), .cs_fall(cs_fall),
    .sclk_rise(sclk_rise), .sdi_s(sdi_s), .piped(piped),
    .sdo_off(cfg.sdo_off), .resp(resp), .sdo(sdo), .sdo_oe(sdo_oe));

  assign presc_code = cfg.presc;
  assign sdo_off    = cfg.sdo_off;
  assign chan_sel   = cfg.chan;
  assign bpf_code   = cfg.bpf;
  assign gain_code  = cfg.gain;
  assign tc_code    = cfg.tc;
endmodule

// File: tb/dualmode_cfg_spi_tb.sv
module dualmode_cfg_spi_tb;
  localparam int H = 5;

  logic       clk = 1'b0;
  logic       rst_n, cs_n, sclk, sdi, integrate, test_n;
  logic [9:0] result;
  logic [2:0] clamp_flags;
  logic       sdo, sdo_oe, sdo_off, chan_sel;
  logic [3:0] presc_code;
  logic [5:0] bpf_code, gain_code;
  logic [4:0] tc_code;

  int   n_chk = 0;
  int   n_bad = 0;
  logic done  = 1'b0;
  logic [7:0] rx;
  logic       rx_oe;

  always #2 clk = ~clk;

  dualmode_cfg_spi u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .integrate(integrate), .test_n(test_n), .result(result),
    .clamp_flags(clamp_flags), .sdo(sdo), .sdo_oe(sdo_oe),
    .presc_code(presc_code), .sdo_off(sdo_off), .chan_sel(chan_sel),
    .bpf_code(bpf_code), .gain_code(gain_code), .tc_code(tc_code));

  // pipelined-mode sequence: {command, expected response byte}
  localparam logic [15:0] VEC [9] = '{
    16'h44_8E, 16'hE1_B5, 16'h27_80, 16'h94_01, 16'hC3_E0,
    16'h71_71, 16'h72_8E, 16'h50_00, 16'h00_B5 };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [7:0] b, input int nbits);
    rx    = '0;
    rx_oe = 1'b1;
    cs_n  = 1'b0;
    wait_clk(6);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 8) ? b[7-i] : 1'b0;
      wait_clk(H);
      sclk = 1'b1;
      wait_clk(H);
      if (i < 8) rx[7-i] = sdo;
      rx_oe = rx_oe & sdo_oe;
      sclk = 1'b0;
      wait_clk(H);
    end
    cs_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cs_n  = 1'b1;
    sclk  = 1'b0;
    sdi   = 1'b1;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
  endtask

  function automatic logic [22:0] regs();
    return {presc_code, sdo_off, chan_sel, bpf_code, gain_code, tc_code};
  endfunction

  initial begin
    integrate   = 1'b0;
    test_n      = 1'b1;
    result      = 10'h2B5;
    clamp_flags = 3'b101;
    do_reset();

    chk(regs() == 23'd0, "R1 reset values", 32'(regs()), 0);
    chk(sdo_oe == 1'b0, "R1 oe idle", 32'(sdo_oe), 0);

    // R1/R2: clocking with chip select high is ignored
    begin
      logic oe_seen;
      oe_seen = 1'b0;
      for (int i = 0; i < 8; i++) begin
        sdi = i[0];
        wait_clk(H); sclk = 1'b1; wait_clk(H);
        oe_seen = oe_seen | sdo_oe;
        sclk = 1'b0;
      end
      wait_clk(8);
      chk(regs() == 23'd0 && !oe_seen, "R1 cs high ignored",
          32'({oe_seen, regs()}), 0);
    end

    frame(8'hA5, 8);
    chk(rx == 8'hA5, "R7 echo", 32'(rx), 32'hA5);
    chk(rx_oe == 1'b1, "R6 oe in frame", 32'(rx_oe), 1);
    chk(gain_code == 6'h25, "R5 gain write", 32'(gain_code), 32'h25);

    frame(8'h4B, 8);
    chk({presc_code, sdo_off} == 5'h0B, "R4 prescaler+off", 32'({presc_code, sdo_off}), 32'h0B);
    frame(8'h44, 8);
    chk(rx_oe == 1'b0, "R6 disabled sdo", 32'(rx_oe), 0);
    chk({presc_code, sdo_off} == 5'h04, "R4 prescaler 2", 32'({presc_code, sdo_off}), 32'h04);
    frame(8'h5A, 8);
    chk({presc_code, sdo_off} == 5'h04, "R4 code above 8 ignored", 32'({presc_code, sdo_off}), 32'h04);

    frame(8'h9F, 7);
    chk(gain_code == 6'h25, "R2 short frame", 32'(gain_code), 32'h25);
    frame(8'h9F, 9);
    chk(gain_code == 6'h25, "R2 long frame", 32'(gain_code), 32'h25);

    integrate = 1'b1;
    frame(8'h83, 8);
    integrate = 1'b0;
    chk(gain_code == 6'h25, "R3 integrate discards", 32'(gain_code), 32'h25);

    frame(8'hE1, 8);
    chk(chan_sel == 1'b1, "R5 channel", 32'(chan_sel), 1);
    frame(8'hE3, 8);
    chk(chan_sel == 1'b1, "R5 unknown byte", 32'(chan_sel), 1);
    frame(8'h27, 8);
    frame(8'hC3, 8);
    chk({bpf_code, tc_code} == {6'h27, 5'h03}, "R5 bpf and tc",
        32'({bpf_code, tc_code}), 32'({6'h27, 5'h03}));

    frame(8'hF8, 8);
    frame(8'h3C, 8);
    chk(rx == 8'h3C, "R10 F8 ignored with test high", 32'(rx), 32'h3C);

    frame(8'h71, 8);
    chk(rx == 8'h71, "R7 echo of switch byte", 32'(rx), 32'h71);

    for (int k = 0; k < 9; k++) begin
      frame(VEC[k][15:8], 8);
      chk(rx == VEC[k][7:0], "R9 pipelined response", 32'(rx), 32'(VEC[k][7:0]));
    end
    chk(regs() == {4'd8, 1'b0, 1'b1, 6'h00, 6'h14, 5'h03}, "R5 register image",
        32'(regs()), 32'({4'd8, 1'b0, 1'b1, 6'h00, 6'h14, 5'h03}));

    frame(8'hFF, 5);
    frame(8'hC0, 8);
    chk(rx == 8'h01, "R2 short frame keeps response", 32'(rx), 32'h01);
    integrate = 1'b1;
    frame(8'h10, 8);
    integrate = 1'b0;
    frame(8'h01, 8);
    chk(rx == 8'h71, "R3 discarded frame keeps response", 32'(rx), 32'h71);

    test_n = 1'b0;
    do_reset();
    chk(regs() == 23'd0, "R1 second reset", 32'(regs()), 0);
    frame(8'hF8, 8);
    chk(rx == 8'hF8, "R8 reset returns echo", 32'(rx), 32'hF8);
    frame(8'h40, 8);
    chk(rx == 8'h05, "R10 clamp flags", 32'(rx), 32'h05);
    frame(8'hAA, 8);
    chk(rx == 8'hB5, "R8 pipelined after test command", 32'(rx), 32'hB5);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule